// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked system read and write an external asynchronous static RAM of one million 4-bit words. The RAM has three active-low strobes: chip enable, output enable and write enable. The controller turns each request from the user side into a sequence of strobe phases. Each phase lasts a whole number of clock cycles, and those counts are parameters. They are chosen from the clock period so that the RAM's minimum pulse widths, its access time and its bus-release delays are covered.

The user side uses a request/ready handshake. A request is taken on a clock edge where `req_i` and `ready_o` are both high. At that edge the controller latches the read/write flag, the address and the write data. Read data comes back in a register, with a pulse on `rvalid_o` that lasts one cycle. On the memory side the controller drives the address and the strobes. It has a split data bus: a data output, an explicit enable for the controller's own driver, and a data input.

All write cycles are controlled by write enable. Output enable stays high throughout every write, and every read is followed by a turnaround of idle cycles before the bus can be driven again.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all three strobes are high (1 = inactive), `mem_dq_oe_o` is 0, `ready_o` is 1 and `rvalid_o` is 0.
- R2: A read holds chip enable and output enable low, with write enable high, for exactly RD_CYC cycles (default 4). Data on `mem_dq_i` is captured at the clock edge that ends this phase. `rvalid_o` is high for one cycle, the (RD_CYC+1)th cycle after the accepting edge, and `rdata_o` shows the captured word in that cycle.
- R3: A write first spends one cycle with chip enable low, write enable high and the data driver on. Write enable then stays low for exactly WR_PULSE_CYC cycles (default 2). The driver is on in every cycle where write enable is low, and it turns off in the same cycle that write enable rises.
- R4: After write enable rises, chip enable stays low, with the driver off, for WR_REC_CYC cycles (default 1). Chip enable is therefore low for 1+WR_PULSE_CYC+WR_REC_CYC cycles in total for each write.
- R5: After every read, all strobes stay high for TURN_CYC cycles (default 2, minimum 1). `ready_o` stays low during those cycles, so at least TURN_CYC+1 cycles with chip enable high separate the end of a read from the next access.
- R6: `ready_o` is high only when the controller is idle. It stays low from the accepting edge until the last phase ends: RD_CYC+TURN_CYC cycles for a read and 1+WR_PULSE_CYC+WR_REC_CYC cycles for a write. A request raised and dropped while `ready_o` is low is ignored: no memory word changes and no read data is returned.
- R7: The controller never drives the data bus while output enable is low, and output enable and write enable are never low together.
- R8: While chip enable stays low, `mem_addr_o` does not change, and neither does `mem_dq_o` while the driver is on.
- R9: Whenever chip enable is high, output enable and write enable are high too.
- R10: A word written to an address, including the lowest and highest addresses, is returned by a later read of that address. A later write to the same address replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| wr_i | input | 1 | 1 = write, 0 = read; sampled with the request |
| addr_i | input | 20 | Word address |
| wdata_i | input | 4 | Write data |
| ready_o | output | 1 | Idle; a request is taken on an edge where this is high |
| rdata_o | output | 4 | Registered read data |
| rvalid_o | output | 1 | One-cycle pulse marking valid read data |
| mem_addr_o | output | 20 | Memory address |
| mem_ce_n_o | output | 1 | Memory chip enable, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_dq_o | output | 4 | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Enable for the controller's data driver |
| mem_dq_i | input | 4 | Data read from the memory bus |

## Verification
The assertions check the following on every cycle:
- the strobe combinations that avoid contention (R7, R9);
- that the driver is on before and during the write pulse, and the pulse width that a counter measures (R3);
- the turnaround count between output enable and the next driver enable (R5);
- stability of the address and data while the memory is selected (R8).

Only the bench scenarios can show the rest:
- phase lengths measured against the requirement numbers;
- the read latency and the capture point, using a memory model that holds its data invalid until the access time has passed;
- that a request pulsed while busy is lost;
- the data round trips at the lowest and highest addresses, including overwrites.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD,
    PH_TURN,
    PH_WSET,
    PH_WPUL,
    PH_WREC
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC       = 4,
  parameter int unsigned WR_PULSE_CYC = 2,
  parameter int unsigned WR_REC_CYC   = 1,
  parameter int unsigned TURN_CYC     = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    is_wr_i,
  output logic    ready_o,
  output logic    capture_o,
  output strobe_t strobe_o
);

  localparam int unsigned L_RD  = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int unsigned L_WR  = (WR_PULSE_CYC > WR_REC_CYC) ? WR_PULSE_CYC : WR_REC_CYC;
  localparam int unsigned L_MAX = (L_RD > L_WR) ? L_RD : L_WR;
  localparam int unsigned CNT_W = $clog2(L_MAX + 1);

  phase_e phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  strobe_t strobe_q;
  logic last;

  function automatic int unsigned ph_len(phase_e p);
    case (p)
      PH_RD:   return RD_CYC;
      PH_TURN: return TURN_CYC;
      PH_WPUL: return WR_PULSE_CYC;
      PH_WREC: return WR_REC_CYC;
      default: return 1;
    endcase
  endfunction

  function automatic strobe_t decode(phase_e p);
    strobe_t s;
    s = STROBE_OFF;
    case (p)
      PH_RD:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      PH_WSET: begin s.ce_n = 1'b0; s.drv = 1'b1; end
      PH_WPUL: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drv = 1'b1; end
      PH_WREC: begin s.ce_n = 1'b0; end
      default: s = STROBE_OFF;
    endcase
    return s;
  endfunction

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = is_wr_i ? PH_WSET : PH_RD;
      PH_RD:   if (last) phase_d = PH_TURN;
      PH_TURN: if (last) phase_d = PH_IDLE;
      PH_WSET: if (last) phase_d = PH_WPUL;
      PH_WPUL: if (last) phase_d = PH_WREC;
      PH_WREC: if (last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    if (phase_d != phase_q)  cnt_d = CNT_W'(ph_len(phase_d) - 1);
    else if (last)           cnt_d = '0;
    else                     cnt_d = cnt_q - 1'b1;
  end

  // strobes registered from the next phase: glitch-free, aligned with phase_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      strobe_q <= STROBE_OFF;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      strobe_q <= decode(phase_d);
    end
  end

  assign ready_o   = (phase_q == PH_IDLE);
  assign capture_o = (phase_q == PH_RD) && last;
  assign strobe_o  = strobe_q;

  // checker counters
  logic [CNT_W:0] we_low_cnt, oe_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt <= '0;
      oe_hi_cnt  <= '1;
    end else begin
      we_low_cnt <= strobe_q.we_n ? '0 : ((&we_low_cnt) ? we_low_cnt : we_low_cnt + 1'b1);
      oe_hi_cnt  <= !strobe_q.oe_n ? '0 : ((&oe_hi_cnt) ? oe_hi_cnt : oe_hi_cnt + 1'b1);
    end
  end

  // R9
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q.ce_n |-> (strobe_q.oe_n && strobe_q.we_n));

  // R7
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_q.drv |-> strobe_q.oe_n);

  // R7
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_q.we_n |-> strobe_q.oe_n);

  // R3
  drive_before_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_q.we_n) |-> $past(strobe_q.drv));

  // R3
  drive_during_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_q.we_n |-> strobe_q.drv);

  // R3
  we_pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_q.we_n) |-> (we_low_cnt == (CNT_W+1)'(WR_PULSE_CYC)));

  // R5
  turnaround_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_q.drv) |-> (oe_hi_cnt >= (CNT_W+1)'(TURN_CYC)));

  // R6
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_q.ce_n |-> !ready_o);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o   = addr_q;
  assign dq_o     = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R2
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned DATA_W       = 4,
  parameter int unsigned RD_CYC       = 4,
  parameter int unsigned WR_PULSE_CYC = 2,
  parameter int unsigned WR_REC_CYC   = 1,
  parameter int unsigned TURN_CYC     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic    accept, capture, ready;
  strobe_t strobe;

  assign accept = req_i && ready;

  sram_seq_fsm #(
    .RD_CYC       (RD_CYC),
    .WR_PULSE_CYC (WR_PULSE_CYC),
    .WR_REC_CYC   (WR_REC_CYC),
    .TURN_CYC     (TURN_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (req_i),
    .is_wr_i   (wr_i),
    .ready_o   (ready),
    .capture_o (capture),
    .strobe_o  (strobe)
  );

  sram_data_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .capture_i (capture),
    .dq_i      (mem_dq_i),
    .addr_o    (mem_addr_o),
    .dq_o      (mem_dq_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign ready_o     = ready;
  assign mem_ce_n_o  = strobe.ce_n;
  assign mem_oe_n_o  = strobe.oe_n;
  assign mem_we_n_o  = strobe.we_n;
  assign mem_dq_oe_o = strobe.drv;

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

  // R8
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

  // R2
  rvalid_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> ($past(!mem_oe_n_o) && mem_oe_n_o));

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int RD   = 4;
  localparam int WP   = 2;
  localparam int WREC = 1;
  localparam int TURN = 2;
  localparam int ACC  = 3; // memory access time in cycles (20 ns at 8 ns)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        ready, rvalid, ce_n, oe_n, we_n, dq_oe;
  logic [3:0]  rdata, dq_o, dq_i;
  logic [19:0] maddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sram_async_ctrl #(
    .RD_CYC(RD), .WR_PULSE_CYC(WP), .WR_REC_CYC(WREC), .TURN_CYC(TURN)
  ) u_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_addr_o(maddr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req_tag, act, exp, $time);
    end
  endtask

  // memory model
  logic [3:0] mem [int];
  logic [3:0] ref_mem [int];
  int acc_cnt = 0;

  function automatic logic [3:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 4'h0;
  endfunction

  function automatic logic [3:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 4'h0;
  endfunction

  always @(posedge clk) acc_cnt <= (!ce_n && !oe_n && we_n) ? acc_cnt + 1 : 0;

  always @(*) begin
    if (!ce_n && !oe_n && we_n && acc_cnt >= ACC) dq_i = mem_rd(int'(maddr));
    else                                          dq_i = ~mem_rd(int'(maddr));
  end

  always @(negedge clk) if (!ce_n && !we_n && dq_oe) mem[int'(maddr)] = dq_o;

  // scoreboard
  logic [3:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected rvalid", 1, 0);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(rdata == e, "R10 read data", int'(rdata), int'(e));
      end
    end
  end

  // strobe timing monitor
  bit   prev_ce_n = 1'b1;
  bit   last_rd = 1'b0;
  bit   addr_ok = 1'b1;
  int   ce_run = 0, we_run = 0, oe_run = 0, gap = 100;
  logic [19:0] start_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe) check(oe_n, "R7 drive with oe low", int'(oe_n), 1);
      if (!we_n) check(dq_oe && oe_n, "R3 we low without driver", int'(dq_oe), 1);
      if (ce_n && (!oe_n || !we_n)) check(1'b0, "R9 strobe while deselected", int'({oe_n, we_n}), 3);
      if (!ce_n) begin
        if (prev_ce_n) begin
          if (last_rd) check(gap >= TURN + 1, "R5 gap after read", gap, TURN + 1);
          start_addr = maddr;
          addr_ok = 1'b1;
        end
        if (maddr != start_addr) addr_ok = 1'b0;
        ce_run++;
        if (!we_n) we_run++;
        if (!oe_n) oe_run++;
        gap = 0;
      end else begin
        if (!prev_ce_n) begin
          check(addr_ok, "R8 address held", int'(addr_ok), 1);
          if (we_run > 0) begin
            check(we_run == WP, "R3 we pulse", we_run, WP);
            check(oe_run == 0, "R7 oe during write", oe_run, 0);
            check(ce_run == 1 + WP + WREC, "R4 write ce length", ce_run, 1 + WP + WREC);
            last_rd = 1'b0;
          end else begin
            check(oe_run == RD, "R2 oe length", oe_run, RD);
            check(ce_run == RD, "R2 ce length", ce_run, RD);
            last_rd = 1'b1;
          end
          ce_run = 0; we_run = 0; oe_run = 0;
        end
        gap++;
      end
      prev_ce_n = ce_n;
    end
  end

  // driver
  task automatic issue(input bit w, input logic [19:0] a, input logic [3:0] d, input bit spurious);
    int n, rv_n;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(posedge clk);
    if (w) ref_mem[int'(a)] = d;
    else   exp_q.push_back(ref_rd(int'(a)));
    @(negedge clk);
    req = 1'b0;
    n = 1;
    rv_n = 0;
    while (!ready) begin
      if (rvalid && rv_n == 0) rv_n = n;
      if (spurious && n == 1) begin
        req = 1'b1; wr = ~w; addr = a ^ 20'h00001; wdata = ~d;
      end
      if (spurious && n == 2) req = 1'b0;
      @(negedge clk);
      n++;
    end
    if (rvalid && rv_n == 0) rv_n = n;
    if (w) begin
      check(n == 1 + WP + WREC + 1, "R6 write busy time", n, 1 + WP + WREC + 1);
    end else begin
      check(n == RD + TURN + 1, "R6 read busy time", n, RD + TURN + 1);
      check(rv_n == RD + 1, "R2 rvalid latency", rv_n, RD + 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(ce_n && oe_n && we_n, "R1 strobes in reset", int'({ce_n, oe_n, we_n}), 7);
    check(!dq_oe, "R1 driver in reset", int'(dq_oe), 0);
    check(ready && !rvalid, "R1 ready/rvalid in reset", int'({ready, rvalid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe, "R1 after reset", int'({ce_n, oe_n, we_n, dq_oe}), 14);

    issue(1'b1, 20'h00000, 4'h5, 1'b0);
    issue(1'b1, 20'hFFFFF, 4'hA, 1'b0);
    issue(1'b0, 20'h00000, 4'h0, 1'b0);
    issue(1'b0, 20'hFFFFF, 4'h0, 1'b0);
    issue(1'b1, 20'h12345, 4'hF, 1'b0);   // read followed by write: turnaround
    issue(1'b0, 20'h12345, 4'h0, 1'b0);   // write followed by read
    issue(1'b1, 20'h12345, 4'h0, 1'b0);   // overwrite
    issue(1'b0, 20'h12345, 4'h0, 1'b0);
    // R6: requests pulsed while busy are ignored
    issue(1'b1, 20'h0AAA0, 4'h3, 1'b1);
    issue(1'b0, 20'h0AAA0, 4'h0, 1'b1);
    issue(1'b0, 20'h0AAA1, 4'h0, 1'b0);   // spurious write target unchanged
    for (int i = 0; i < 8; i++) issue(1'b1, 20'(i * 20'h1F3D1), 4'(i * 3 + 1), 1'b0);
    for (int i = 0; i < 8; i++) issue(1'b0, 20'(i * 20'h1F3D1), 4'h0, 1'b0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule